// File: doc/BRIEF.md
# Descriptor Done-Queue Pointer Manager

This block keeps the bookkeeping registers for a circular done queue that lives in host memory. A DMA engine writes an entry into the queue each time it finishes with a descriptor. A host processor later reads those entries back out. The block stores four things:

- the queue base address, written as two 16-bit halves;
- the queue end, given as an index relative to the base;
- a write pointer, owned by the DMA side;
- a read pointer, owned by the host.

The DMA side asks for a slot by raising a push request. In the same cycle the block shows the byte address of the slot the write pointer names. If there is room, it accepts the push, and the write pointer moves on at the next clock edge. After the last index it wraps back to zero.

The host sees the registers through a simple 16-bit register port. It uses an init-enable control bit to open the write pointer for setup. After setup the write pointer belongs to the DMA side alone. The host then consumes entries by moving the read pointer. Empty and full are worked out from the pointers and the end index. One slot always stays unused, so that a full queue can be told apart from an empty one.

Top module: `dq_ptr_mgr`

## Requirements
- R1: After reset every register reads zero. Empty is 1. Full is also 1, because an end index of zero leaves a one-slot queue with no usable entry.
- R2: Register offsets are: 0 base low half, 1 base high half, 2 end index, 3 write pointer, 4 read pointer, 5 flush-timer value, 6 control (bit 0 = init enable), 7 status. Registers 0, 1, 2, 5 and 6 read back the last value written to them, and the read data is combinational on the offset.
- R3: A push while full is refused. The acknowledge stays low and the overflow output pulses high in that cycle. The write pointer keeps its value, and the sticky overflow status bit gets set.
- R4: The entry address output equals ({base high, base low} + write pointer × 4), taken modulo 2^32.
- R5: An accepted push moves the write pointer to pointer + 1 at the next edge. If the pointer already equals the end index, it goes to zero instead.
- R6: Empty is 1 exactly when the read pointer equals the write pointer.
- R7: Full is 1 exactly when the next write position (after the wrap of R5) equals the read pointer. This includes the case of write pointer = end index with read pointer = 0.
- R8: A host write to offset 3 while init enable is 0 has no effect. While init enable is 1, the write pointer takes the written value.
- R9: While init enable is 1, a push is ignored. There is no acknowledge, no overflow and no pointer change.
- R10: The status register is read-only except for its bit 2. Bit 0 is empty, bit 1 is full and bit 2 is the sticky overflow flag. Writing 1 to bit 2 clears the flag, but a refused push in the same cycle wins.
- R11: The queue end address output equals ({base high, base low} + end index × 4), taken modulo 2^32.
- R12: Only host writes to offset 4 change the read pointer. Pushes never move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Host register write strobe |
| regAddr | input | 3 | Host register offset |
| regWdata | input | 16 | Host write data |
| regRdata | output | 16 | Host read data for regAddr |
| dmaPush | input | 1 | DMA request to post one done entry |
| dmaAck | output | 1 | Push accepted this cycle |
| dmaOvf | output | 1 | Push refused because the queue is full |
| dmaAddr | output | 32 | Byte address of the slot under the write pointer |
| qEndAddr | output | 32 | Absolute byte address of the last slot |
| qEmpty | output | 1 | Queue empty |
| qFull | output | 1 | Queue full |

## Verification
The bench aims at three corners:

- **Wrap boundary.** A design that compares against end + 1, or that wraps one entry late, would hand the DMA an address past the queue end. It would also report full one slot too late when the read pointer sits at zero.
- **Refused push.** A design that still advances the write pointer on a refused push would make a full queue look empty, and entries would be lost.
- **Ownership rules.** The bench tries host writes to the write pointer outside setup, pushes during setup, and a clear of the overflow flag in the same cycle as a new overflow. A design that gets these wrong would corrupt the DMA pointer, or lose an overflow event.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2 * REG_W;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_BASE_LO = 3'd0;
  localparam logic [OFS_W-1:0] OFS_BASE_HI = 3'd1;
  localparam logic [OFS_W-1:0] OFS_END     = 3'd2;
  localparam logic [OFS_W-1:0] OFS_WR_PTR  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_RD_PTR  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_FLUSH   = 3'd5;
  localparam logic [OFS_W-1:0] OFS_CTRL    = 3'd6;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 3'd7;

  localparam int ST_EMPTY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_OVF   = 2;

  typedef struct packed {
    logic ldBaseLo;
    logic ldBaseHi;
    logic ldEnd;
    logic ldWrPtr;
    logic ldRdPtr;
    logic ldFlush;
    logic ldCtrl;
    logic clrOvf;
    logic advWrPtr;
    logic setOvf;
  } dqStrobe_t;
endpackage

// File: rtl/dq_ctrl.sv
module dq_ctrl
  import dq_pkg::*;
(
  input  logic             regWe,
  input  logic [OFS_W-1:0] regAddr,
  input  logic [REG_W-1:0] regWdata,
  input  logic             dmaPush,
  input  logic             initEn,
  input  logic             full,
  output dqStrobe_t        strb,
  output logic             dmaAck,
  output logic             dmaOvf
);
  logic pushLive;

  always_comb begin
    pushLive = dmaPush && !initEn;
    dmaAck   = pushLive && !full;
    dmaOvf   = pushLive && full;
  end

  always_comb begin
    strb          = '0;
    strb.advWrPtr = dmaAck;
    strb.setOvf   = dmaOvf;
    if (regWe) begin
      unique case (regAddr)
        OFS_BASE_LO: strb.ldBaseLo = 1'b1;
        OFS_BASE_HI: strb.ldBaseHi = 1'b1;
        OFS_END:     strb.ldEnd    = 1'b1;
        OFS_WR_PTR:  strb.ldWrPtr  = initEn;
        OFS_RD_PTR:  strb.ldRdPtr  = 1'b1;
        OFS_FLUSH:   strb.ldFlush  = 1'b1;
        OFS_CTRL:    strb.ldCtrl   = 1'b1;
        OFS_STATUS:  strb.clrOvf   = regWdata[ST_OVF];
        default:     strb          = strb;
      endcase
    end
  end
endmodule

// File: rtl/dq_datapath.sv
module dq_datapath
  import dq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dqStrobe_t         strb,
  input  logic [OFS_W-1:0]  regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [ADDR_W-1:0] qEndAddr,
  output logic              qEmpty,
  output logic              qFull,
  output logic [REG_W-1:0]  wrPtr,
  output logic [REG_W-1:0]  rdPtr,
  output logic [REG_W-1:0]  endIdx,
  output logic              initEn
);
  localparam int PAD_W = ADDR_W - REG_W - 2;

  logic [REG_W-1:0]  baseLo, baseHi, flushVal;
  logic              ovfSticky;
  logic [REG_W-1:0]  wrPtrNxt;
  logic [ADDR_W-1:0] baseAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseLo    <= '0;
      baseHi    <= '0;
      endIdx    <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      flushVal  <= '0;
      initEn    <= 1'b0;
      ovfSticky <= 1'b0;
    end else begin
      if (strb.ldBaseLo) baseLo   <= regWdata;
      if (strb.ldBaseHi) baseHi   <= regWdata;
      if (strb.ldEnd)    endIdx   <= regWdata;
      if (strb.ldFlush)  flushVal <= regWdata;
      if (strb.ldCtrl)   initEn   <= regWdata[0];
      if (strb.ldRdPtr)  rdPtr    <= regWdata;
      if (strb.ldWrPtr)       wrPtr <= regWdata;
      else if (strb.advWrPtr) wrPtr <= wrPtrNxt;
      if (strb.setOvf)      ovfSticky <= 1'b1;
      else if (strb.clrOvf) ovfSticky <= 1'b0;
    end
  end

  always_comb begin
    wrPtrNxt = (wrPtr == endIdx) ? '0 : wrPtr + 1'b1;
    qEmpty   = (rdPtr == wrPtr);
    qFull    = (wrPtrNxt == rdPtr);
    baseAddr = {baseHi, baseLo};
    dmaAddr  = baseAddr + {{PAD_W{1'b0}}, wrPtr, 2'b00};
    qEndAddr = baseAddr + {{PAD_W{1'b0}}, endIdx, 2'b00};
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      OFS_BASE_LO: regRdata = baseLo;
      OFS_BASE_HI: regRdata = baseHi;
      OFS_END:     regRdata = endIdx;
      OFS_WR_PTR:  regRdata = wrPtr;
      OFS_RD_PTR:  regRdata = rdPtr;
      OFS_FLUSH:   regRdata = flushVal;
      OFS_CTRL:    regRdata[0] = initEn;
      OFS_STATUS: begin
        regRdata[ST_EMPTY] = qEmpty;
        regRdata[ST_FULL]  = qFull;
        regRdata[ST_OVF]   = ovfSticky;
      end
      default:     regRdata = '0;
    endcase
  end
endmodule

// File: rtl/dq_ptr_mgr.sv
module dq_ptr_mgr
  import dq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [OFS_W-1:0]  regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              dmaPush,
  output logic              dmaAck,
  output logic              dmaOvf,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [ADDR_W-1:0] qEndAddr,
  output logic              qEmpty,
  output logic              qFull
);
  dqStrobe_t        strb;
  logic [REG_W-1:0] wrPtr, rdPtr, endIdx;
  logic             initEn;

  dq_ctrl u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .dmaPush(dmaPush), .initEn(initEn), .full(qFull),
    .strb(strb), .dmaAck(dmaAck), .dmaOvf(dmaOvf)
  );

  dq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dmaAddr(dmaAddr),
    .qEndAddr(qEndAddr), .qEmpty(qEmpty), .qFull(qFull),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .endIdx(endIdx), .initEn(initEn)
  );
endmodule

// File: rtl/dq_ptr_mgr_chk.sv
module dq_ptr_mgr_chk
  import dq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic [OFS_W-1:0] regAddr,
  input logic             dmaPush,
  input logic             dmaAck,
  input logic             dmaOvf,
  input logic             qEmpty,
  input logic             qFull,
  input logic [REG_W-1:0] wrPtr,
  input logic [REG_W-1:0] rdPtr,
  input logic [REG_W-1:0] endIdx,
  input logic             initEn
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (dmaPush && qFull && !initEn) |=> $stable(wrPtr)); // R3
  AST_ACK_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    dmaAck |-> (!qFull && !dmaOvf)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAck && wrPtr == endIdx) |=> (wrPtr == '0)); // R5
  AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (endIdx != '0 && qEmpty) |-> !qFull); // R6
  AST_WP_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!initEn && !dmaAck) |=> $stable(wrPtr)); // R8
  AST_INIT_NO_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    initEn |-> (!dmaAck && !dmaOvf)); // R9
  AST_RP_HOST_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == OFS_RD_PTR) |=> $stable(rdPtr)); // R12
endmodule

bind dq_ptr_mgr dq_ptr_mgr_chk u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .dmaPush(dmaPush), .dmaAck(dmaAck), .dmaOvf(dmaOvf),
  .qEmpty(qEmpty), .qFull(qFull), .wrPtr(wrPtr), .rdPtr(rdPtr),
  .endIdx(endIdx), .initEn(initEn)
);

// File: tb/tb_dq_ptr_mgr.sv
module tb_dq_ptr_mgr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        dmaPush = 1'b0;
  logic        dmaAck, dmaOvf, qEmpty, qFull;
  logic [31:0] dmaAddr, qEndAddr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [15:0] mLo = 0, mHi = 0, mEnd = 0, mWp = 0, mRp = 0, mFlush = 0;
  bit          mInit = 0, mOvf = 0;

  always #4 clk = ~clk;

  dq_ptr_mgr dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dmaPush(dmaPush),
    .dmaAck(dmaAck), .dmaOvf(dmaOvf), .dmaAddr(dmaAddr),
    .qEndAddr(qEndAddr), .qEmpty(qEmpty), .qFull(qFull)
  );

  function automatic logic [15:0] nextWp();
    return (mWp == mEnd) ? 16'd0 : mWp + 16'd1;
  endfunction

  function automatic bit mFull();
    return nextWp() == mRp;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // model update on the same edge the design uses
  always @(posedge clk) begin
    if (rstN) begin
      bit live, ack, ovf;
      live = dmaPush && !mInit;
      ack  = live && !mFull();
      ovf  = live && mFull();
      if (ack) mWp = nextWp();
      if (regWe) begin
        case (regAddr)
          3'd0: mLo = regWdata;
          3'd1: mHi = regWdata;
          3'd2: mEnd = regWdata;
          3'd3: if (mInit) mWp = regWdata;
          3'd4: mRp = regWdata;
          3'd5: mFlush = regWdata;
          3'd6: mInit = regWdata[0];
          default: ;
        endcase
      end
      if (ovf) mOvf = 1;
      else if (regWe && regAddr == 3'd7 && regWdata[2]) mOvf = 0;
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      bit live;
      logic [15:0] exp;
      logic [31:0] base;
      base = {mHi, mLo};
      live = dmaPush && !mInit;
      chk(dmaAck == (live && !mFull()), "R3/R5/R9 ack", dmaAck, live && !mFull());
      chk(dmaOvf == (live && mFull()), "R3/R9 overflow", dmaOvf, live && mFull());
      chk(qEmpty == (mRp == mWp), "R6 empty", qEmpty, mRp == mWp);
      chk(qFull == mFull(), "R7 full", qFull, mFull());
      chk(dmaAddr == base + {14'd0, mWp, 2'b00}, "R4 entry addr", dmaAddr, base + {14'd0, mWp, 2'b00});
      chk(qEndAddr == base + {14'd0, mEnd, 2'b00}, "R11 end addr", qEndAddr, base + {14'd0, mEnd, 2'b00});
      case (regAddr)
        3'd0: exp = mLo;
        3'd1: exp = mHi;
        3'd2: exp = mEnd;
        3'd3: exp = mWp;
        3'd4: exp = mRp;
        3'd5: exp = mFlush;
        3'd6: exp = {15'd0, mInit};
        default: exp = {13'd0, mOvf, mFull(), mRp == mWp};
      endcase
      if (regAddr == 3'd3)      chk(regRdata == exp, "R8 wr ptr read", regRdata, exp);
      else if (regAddr == 3'd4) chk(regRdata == exp, "R12 rd ptr read", regRdata, exp);
      else if (regAddr == 3'd7) chk(regRdata == exp, "R10 status read", regRdata, exp);
      else                      chk(regRdata == exp, "R2 reg read", regRdata, exp);
    end
  end

  task automatic step(input bit we, input logic [2:0] a, input logic [15:0] d, input bit push);
    @(negedge clk);
    regWe = we; regAddr = a; regWdata = d; dmaPush = push;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      step(0, a[2:0], 0, 0); #2;
      chk(regRdata == 16'd0, "R1 reset reg", regRdata, 0);
    end
    step(0, 3'd7, 0, 0); #2;
    chk(regRdata == 16'h0003, "R1 reset status", regRdata, 16'h0003);
    chk(qEmpty && qFull, "R1 empty and full", {qEmpty, qFull}, 2'b11);

    // setup with init enable
    step(1, 3'd6, 16'h0001, 0);
    step(1, 3'd0, 16'h1000, 0);
    step(1, 3'd1, 16'h8000, 0);
    step(1, 3'd2, 16'd3, 0);
    step(1, 3'd5, 16'hBEEF, 0);
    step(1, 3'd3, 16'd2, 0);
    step(1, 3'd4, 16'd2, 0);
    step(0, 3'd3, 0, 1); #2;   // R9: push ignored during init
    chk(!dmaAck && !dmaOvf, "R9 push in init", {dmaAck, dmaOvf}, 0);
    step(0, 3'd3, 0, 0); #2;
    chk(regRdata == 16'd2, "R8 wp set in init", regRdata, 2);
    step(1, 3'd6, 16'h0000, 0);
    step(0, 3'd5, 0, 1); #2;   // push at wp=2
    chk(dmaAddr == 32'h8000_1008, "R4 addr wp2", dmaAddr, 32'h8000_1008);
    chk(regRdata == 16'hBEEF, "R2 flush read", regRdata, 16'hBEEF);
    step(0, 3'd3, 0, 1); #2;   // wp=3 = end, push wraps
    chk(regRdata == 16'd3, "R5 wp at end", regRdata, 3);
    step(0, 3'd3, 0, 1); #2;   // wp=0 after wrap
    chk(regRdata == 16'd0, "R5 wrap to zero", regRdata, 0);
    step(0, 3'd3, 0, 0); #2;   // wp=1, rp=2 -> full
    chk(qFull == 1'b1, "R7 full", qFull, 1);
    step(0, 3'd7, 0, 1); #2;   // refused
    chk(dmaOvf && !dmaAck, "R3 refused", {dmaAck, dmaOvf}, 2'b01);
    step(0, 3'd7, 0, 0); #2;
    chk(regRdata[2] == 1'b1, "R10 sticky ovf", regRdata, 16'h0006);
    step(0, 3'd3, 0, 0); #2;
    chk(regRdata == 16'd1, "R3 wp held", regRdata, 1);
    step(1, 3'd7, 16'h0004, 1); // clear and refused push together: set wins
    step(0, 3'd7, 0, 0); #2;
    chk(regRdata[2] == 1'b1, "R10 set beats clear", regRdata[2], 1);
    step(1, 3'd7, 16'h0004, 0);
    step(0, 3'd7, 0, 0); #2;
    chk(regRdata[2] == 1'b0, "R10 clear", regRdata[2], 0);
    step(1, 3'd3, 16'd0, 0);    // R8: ignored outside init
    step(0, 3'd3, 0, 0); #2;
    chk(regRdata == 16'd1, "R8 wp write ignored", regRdata, 1);
    step(1, 3'd4, 16'd1, 0);
    step(0, 3'd4, 0, 0); #2;
    chk(qEmpty == 1'b1, "R6 empty", qEmpty, 1);
    // full at the wrap boundary: wp=end, rp=0
    step(1, 3'd4, 16'd0, 1);
    step(0, 3'd3, 0, 1);
    step(0, 3'd3, 0, 0); #2;
    chk(regRdata == 16'd3 && qFull, "R7 full at wrap", {regRdata, 15'd0, qFull}, {16'd3, 16'd1});

    // randomized traffic on a longer queue
    step(1, 3'd2, 16'd5, 0);
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0)      step(1, 3'd4, 16'($urandom_range(0, int'(mEnd))), $urandom_range(0, 1) == 1);
      else if (r == 1) step(1, 3'd7, 16'h0004, $urandom_range(0, 1) == 1);
      else if (r == 2) step(1, 3'd3, 16'($urandom_range(0, 5)), 1);
      else             step(0, 3'($urandom_range(0, 7)), 0, $urandom_range(0, 2) != 0);
    end
    step(0, 3'd0, 0, 0);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule